// File: doc/BRIEF.md
# Widescreen Signalling Line Encoder

This block inserts the widescreen signalling burst into the vertical blanking interval of a 625-line video signal. It carries a 14-bit payload: an aspect-ratio group with its own parity bit, enhancement flags, subtitle flags and reserved bits. On one chosen line, and only when insertion is enabled, the block emits a biphase-coded element stream. The stream starts with a fixed run-in, then a fixed start code, then the 14 payload bits, least significant first.

The host loads the payload into two staging inputs. The block copies them into a transmit word only on the frame-sync strobe, so a word written partway through a field is never sent half-updated. Elements run at 5 MHz. They are derived from the 13.5 MHz sample enable with a 10/27 fractional accumulator. The block drives a digital level code and a gate that marks the samples belonging to the burst. Downstream logic mixes the level into the luma path and shapes it.

Top module: `wss_encoder`

## Requirements
- R1: While reset is asserted, and after reset until a burst starts, `gateOut` is 0 and `levelOut` equals LOW_CODE (default 64).
- R2: Payload bit n (n = 0..7) is `payloadLo[n]`, and payload bit 8+m (m = 0..5) is `payloadHi[m]`. Payload bit 0 is transmitted first and bit 13 last.
- R3: Transmitted bit 3 is always the odd-parity bit of the aspect group: it equals the inverse of the XOR of bits 0, 1 and 2. The value the host supplies for bit 3 is ignored.
- R4: The transmit word is copied from the staging inputs only in a clock cycle where `vsyncPulse` is 1. Changes to the staging inputs at other times do not change the next burst.
- R5: A burst starts only on a sample where `lineNum` equals TARGET_LINE (default 23) and `hCount` equals START_SAMPLE (default 149). On every other line the gate stays 0.
- R6: When `insertEn` is 0 at the start sample, no burst is produced on that line.
- R7: A payload bit of 1 is sent as six elements 1,1,1,0,0,0 and a 0 as 0,0,0,1,1,1.
- R8: The burst opens with a 29-element run-in of value 0x1F1C71C7, then a 24-element start code of value 0x1E3C1F, each sent most significant element first. Total length is 137 elements.
- R9: Elements advance at 10/27 of the sample rate. The output on sample s after the burst start carries element floor(10·s/27). The gate is high for exactly 370 consecutive samples, starting two clocks after the start sample is presented. An element step never occurs on two consecutive enabled samples.
- R10: While the gate is high, `levelOut` is HIGH_CODE (default 190) for a 1 element and LOW_CODE for a 0 element. While the gate is low it is LOW_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | 13.5 MHz sample enable |
| vsyncPulse | input | 1 | Frame-sync strobe; loads the transmit word |
| insertEn | input | 1 | Insertion enable |
| lineNum | input | LINE_W (10) | Current line number |
| hCount | input | HCNT_W (10) | Sample position within the line |
| payloadLo | input | 8 | Staged payload bits 0 to 7 |
| payloadHi | input | 6 | Staged payload bits 8 to 13 |
| levelOut | output | LEVEL_W (8) | Output level code |
| gateOut | output | 1 | High on samples belonging to the burst |

## Verification
Assertions check on every cycle that:
- a burst can begin only at the start sample of the target line with insertion enabled;
- the fractional accumulator stays in range and never yields two element steps in a row;
- the transmit word moves only after a frame-sync strobe;
- the level returns to LOW_CODE whenever the gate is low.

The element pattern itself can only be shown by the bench's scenarios. These cover the run-in and start-code contents, the biphase coding of each payload, the regenerated parity bit, the exact 370-sample gate and the held word when staging changes without a strobe. The bench compares full lines against a model it builds from the requirements.

// File: rtl/wss_pkg.sv
`timescale 1ns/1ps
package wss_pkg;
  localparam int DATA_BITS     = 14;
  localparam int LO_BITS       = 8;
  localparam int HI_BITS       = DATA_BITS - LO_BITS;
  localparam int ELEMS_PER_BIT = 6;
  localparam int RUNIN_LEN     = 29;
  localparam logic [RUNIN_LEN-1:0] RUNIN_PAT = 29'h1F1C71C7;
  localparam int SYNC_LEN      = 24;
  localparam logic [SYNC_LEN-1:0]  SYNC_PAT  = 24'h1E3C1F;
  localparam int PRE_LEN       = RUNIN_LEN + SYNC_LEN;
  localparam int FRAME_LEN     = PRE_LEN + DATA_BITS * ELEMS_PER_BIT;

  typedef struct packed {
    logic load;   // capture a fresh frame into the shifter
    logic step;   // advance to the next element
    logic run;    // burst in progress
  } wssStrobe_t;
endpackage

// File: rtl/wss_ctrl.sv
`timescale 1ns/1ps
module wss_ctrl
  import wss_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int HCNT_W       = 10,
  parameter int TARGET_LINE  = 23,
  parameter int START_SAMPLE = 149,
  parameter int RATE_NUM     = 10,
  parameter int RATE_DEN     = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              insertEn,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [HCNT_W-1:0] hCount,
  output wssStrobe_t        strb
);
  localparam int ACC_W = $clog2(RATE_NUM + RATE_DEN + 1);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic             active;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [CNT_W-1:0] elemCnt;
  logic             startHit;
  logic             wrap;

  assign startHit = insertEn && (lineNum == LINE_W'(TARGET_LINE))
                    && (hCount == HCNT_W'(START_SAMPLE));
  assign accNext  = acc + ACC_W'(RATE_NUM);
  assign wrap     = (accNext >= ACC_W'(RATE_DEN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      acc     <= '0;
      elemCnt <= '0;
    end else if (sampleEn) begin
      if (!active) begin
        if (startHit) begin
          active  <= 1'b1;
          acc     <= '0;
          elemCnt <= '0;
        end
      end else if (wrap) begin
        acc <= accNext - ACC_W'(RATE_DEN);
        if (elemCnt == CNT_W'(FRAME_LEN - 1)) active <= 1'b0;
        else elemCnt <= elemCnt + 1'b1;
      end else begin
        acc <= accNext;
      end
    end
  end

  always_comb begin
    strb.load = sampleEn && !active && startHit;
    strb.step = sampleEn && active && wrap;
    strb.run  = active;
  end

  AST_START_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> ($past(lineNum) == LINE_W'(TARGET_LINE)) && $past(insertEn)
                      && ($past(hCount) == HCNT_W'(START_SAMPLE))); // R5 R6
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    acc < ACC_W'(RATE_DEN)); // R9
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> !strb.step); // R9
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> strb.run); // R5
endmodule

// File: rtl/wss_datapath.sv
`timescale 1ns/1ps
module wss_datapath
  import wss_pkg::*;
#(
  parameter int          LEVEL_W      = 8,
  parameter int          HIGH_CODE    = 190,
  parameter int          LOW_CODE     = 64,
  parameter bit          FORCE_PARITY = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic               vsyncPulse,
  input  logic [LO_BITS-1:0] payloadLo,
  input  logic [HI_BITS-1:0] payloadHi,
  input  wssStrobe_t         strb,
  output logic [LEVEL_W-1:0] levelOut,
  output logic               gateOut
);
  logic [DATA_BITS-1:0] shadow;
  logic [DATA_BITS-1:0] txWord;
  logic [FRAME_LEN-1:0] frame;
  logic [FRAME_LEN-1:0] shifter;

  always_ff @(posedge clk) begin
    if (!rstN) shadow <= '0;
    else if (vsyncPulse) shadow <= {payloadHi, payloadLo};
  end

  generate
    if (FORCE_PARITY) begin : g_parity
      assign txWord = {shadow[DATA_BITS-1:4], ~^shadow[2:0], shadow[2:0]};
    end else begin : g_raw
      assign txWord = shadow;
    end
  endgenerate

  assign frame[FRAME_LEN-1 -: RUNIN_LEN]             = RUNIN_PAT;
  assign frame[FRAME_LEN-1-RUNIN_LEN -: SYNC_LEN]    = SYNC_PAT;
  for (genvar i = 0; i < DATA_BITS; i++) begin : g_bits
    assign frame[FRAME_LEN-1-PRE_LEN-i*ELEMS_PER_BIT -: ELEMS_PER_BIT] =
      txWord[i] ? 6'b111000 : 6'b000111;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter  <= '0;
      gateOut  <= 1'b0;
      levelOut <= LEVEL_W'(LOW_CODE);
    end else if (sampleEn) begin
      if (strb.load)      shifter <= frame;
      else if (strb.step) shifter <= {shifter[FRAME_LEN-2:0], 1'b0};
      gateOut  <= strb.run;
      levelOut <= (strb.run && shifter[FRAME_LEN-1]) ? LEVEL_W'(HIGH_CODE)
                                                      : LEVEL_W'(LOW_CODE);
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(vsyncPulse) |-> $stable(shadow)); // R4
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !gateOut |-> levelOut == LEVEL_W'(LOW_CODE)); // R10
endmodule

// File: rtl/wss_encoder.sv
`timescale 1ns/1ps
module wss_encoder
  import wss_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int HCNT_W       = 10,
  parameter int LEVEL_W      = 8,
  parameter int TARGET_LINE  = 23,
  parameter int START_SAMPLE = 149,
  parameter int RATE_NUM     = 10,
  parameter int RATE_DEN     = 27,
  parameter int HIGH_CODE    = 190,
  parameter int LOW_CODE     = 64,
  parameter bit FORCE_PARITY = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic               vsyncPulse,
  input  logic               insertEn,
  input  logic [LINE_W-1:0]  lineNum,
  input  logic [HCNT_W-1:0]  hCount,
  input  logic [7:0]         payloadLo,
  input  logic [5:0]         payloadHi,
  output logic [LEVEL_W-1:0] levelOut,
  output logic               gateOut
);
  wssStrobe_t strb;

  wss_ctrl #(
    .LINE_W(LINE_W), .HCNT_W(HCNT_W), .TARGET_LINE(TARGET_LINE),
    .START_SAMPLE(START_SAMPLE), .RATE_NUM(RATE_NUM), .RATE_DEN(RATE_DEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .insertEn(insertEn),
    .lineNum(lineNum), .hCount(hCount), .strb(strb)
  );

  wss_datapath #(
    .LEVEL_W(LEVEL_W), .HIGH_CODE(HIGH_CODE), .LOW_CODE(LOW_CODE),
    .FORCE_PARITY(FORCE_PARITY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .vsyncPulse(vsyncPulse),
    .payloadLo(payloadLo), .payloadHi(payloadHi), .strb(strb),
    .levelOut(levelOut), .gateOut(gateOut)
  );
endmodule

// File: tb/tb_wss_encoder.sv
`timescale 1ns/1ps
module tb_wss_encoder;
  localparam int START = 149;
  localparam int HIGHC = 190;
  localparam int LOWC  = 64;
  localparam int BURST = 370;
  localparam logic [28:0] RUNIN = 29'h1F1C71C7;
  localparam logic [23:0] SYNCC = 24'h1E3C1F;
  localparam int NVEC = 7;
  // {payloadHi, payloadLo, expected transmitted word}
  localparam logic [27:0] VEC [NVEC] = '{
    {6'h00, 8'h08, 14'h0008},
    {6'h00, 8'h00, 14'h0008},
    {6'h00, 8'h01, 14'h0001},
    {6'h00, 8'h0F, 14'h0007},
    {6'h2D, 8'hA7, 14'h2DA7},
    {6'h3F, 8'hFF, 14'h3FF7},
    {6'h12, 8'h5E, 14'h125E}
  };

  logic clk = 0;
  logic rstN = 0;
  logic sampleEn = 1;
  logic vsyncPulse = 0;
  logic insertEn = 0;
  logic [9:0] lineNum = 10'd1;
  logic [9:0] hCount = 10'd0;
  logic [7:0] payloadLo = 8'h00;
  logic [5:0] payloadHi = 6'h00;
  logic [7:0] levelOut;
  logic gateOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wss_encoder dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .vsyncPulse(vsyncPulse),
    .insertEn(insertEn), .lineNum(lineNum), .hCount(hCount),
    .payloadLo(payloadLo), .payloadHi(payloadHi),
    .levelOut(levelOut), .gateOut(gateOut)
  );

  function automatic bit elemBit(input logic [13:0] w, input int k);
    int d;
    if (k < 29) return RUNIN[28-k];
    if (k < 53) return SYNCC[23-(k-29)];
    d = k - 53;
    return ((d % 6) < 3) ? w[d/6] : !w[d/6];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseVsync();
    @(negedge clk);
    lineNum = 10'd1; hCount = 10'd0; vsyncPulse = 1;
    @(negedge clk);
    vsyncPulse = 0;
  endtask

  // Runs a full line; returns mismatch count, gate count and first mismatch.
  task automatic runLine(input int ln, input bit en, input logic [13:0] w,
                         input bit expOn, output int mism, output int gates,
                         output int firstAct, output int firstExp);
    mism = 0; gates = 0; firstAct = 0; firstExp = 0;
    lineNum = 10'(ln); insertEn = en;
    for (int h = 0; h <= 864; h++) begin
      @(negedge clk);
      if (h > 0) begin
        int s;
        bit eg;
        int el;
        s = h - 1 - START - 1;
        eg = expOn && (s >= 0) && (s < BURST);
        el = (eg && elemBit(w, (s * 10) / 27)) ? HIGHC : LOWC;
        if (gateOut) gates++;
        if (gateOut !== eg || levelOut !== 8'(el)) begin
          if (mism == 0) begin
            firstAct = {gateOut, levelOut};
            firstExp = {eg, 8'(el)};
          end
          mism++;
        end
      end
      hCount = (h < 864) ? 10'(h) : 10'd0;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int m, g, fa, fe;
    repeat (5) @(negedge clk);
    check(gateOut === 1'b0, "R1 gate in reset", gateOut, 0);
    check(levelOut === 8'(LOWC), "R1 level in reset", levelOut, LOWC);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(gateOut === 1'b0 && levelOut === 8'(LOWC), "R1 after reset",
          {gateOut, levelOut}, LOWC);

    for (int i = 0; i < NVEC; i++) begin
      payloadHi = VEC[i][27:22];
      payloadLo = VEC[i][21:14];
      pulseVsync();
      runLine(23, 1'b1, VEC[i][13:0], 1'b1, m, g, fa, fe);
      check(m == 0, $sformatf("R2 R3 R7 R8 R10 stream vector %0d", i), fa, fe);
      check(g == BURST, $sformatf("R9 gate length vector %0d", i), g, BURST);
    end

    // R4: staging changes without a strobe leave the burst unchanged.
    payloadHi = 6'h3F; payloadLo = 8'h00;
    runLine(23, 1'b1, VEC[NVEC-1][13:0], 1'b1, m, g, fa, fe);
    check(m == 0, "R4 word held without vsync", fa, fe);
    pulseVsync();
    runLine(23, 1'b1, 14'h3F08, 1'b1, m, g, fa, fe);
    check(m == 0, "R4 word taken at vsync", fa, fe);

    // R5: neighbouring lines carry no burst.
    runLine(22, 1'b1, 14'h3F08, 1'b0, m, g, fa, fe);
    check(g == 0 && m == 0, "R5 line 22 idle", g, 0);
    runLine(24, 1'b1, 14'h3F08, 1'b0, m, g, fa, fe);
    check(g == 0 && m == 0, "R5 line 24 idle", g, 0);

    // R6: insertion disabled on the target line.
    runLine(23, 1'b0, 14'h3F08, 1'b0, m, g, fa, fe);
    check(g == 0 && m == 0, "R6 disabled line idle", g, 0);

    // Re-enable after disable: burst returns.
    runLine(23, 1'b1, 14'h3F08, 1'b1, m, g, fa, fe);
    check(m == 0 && g == BURST, "R6 R9 re-enabled burst", fa, fe);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule